// File: doc/BRIEF.md
# Seconds Counter Timekeeper with Alarm

This block keeps wall-clock time as a 32-bit count of seconds on a small 32-bit register bus. A slow time base delivers a one-clock `tick` pulse, synchronous to the bus clock, once per second. While counting is enabled, each pulse advances the counter and raises a per-second flag. A separate compare register raises an alarm flag when it equals the counter. Each flag has its own interrupt enable, and both feed a single interrupt line. A scratch word and a trim word give software plain storage.

Every register write is gated twice. Software first writes a key value to the unlock register, which opens a window for exactly one write. That write must also arrive while the ready status bit is high. After an accepted write, ready stays low for a fixed number of bus clocks while the write commits. Any write that misses either condition is dropped without effect. Reads are always allowed and have no side effects. The two flags clear only where a 0 is written over them: writing 1 leaves a flag as it is, so a read-modify-write of the control word cannot lose a pending event.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset, control (0x00) reads 0x0000_0080 (only ready set). Seconds (0x04), alarm (0x08), trim (0x0C), scratch (0x34) and unlock (0x3C) read 0, and `irq` is low.
- R2: While the unlock bit (bit 31 of 0x3C) is clear, a write to any other register leaves every register unchanged.
- R3: A write to 0x3C whose low 16 bits equal `UNLOCK_KEY` (default 0xA55A) sets bit 31 of 0x3C. Any other value written there is ignored. The bit clears again after one accepted register write.
- R4: After an accepted register write, control bit 7 (ready) reads 0 for exactly `READY_CYC` bus clocks. Any write issued while it is 0 is ignored, and this includes a key write.
- R5: While control bit 0 is 1, each `tick` pulse adds one to the seconds counter. With bit 0 clear, a tick leaves the counter unchanged. A seconds write in the same cycle as a tick wins.
- R6: The seconds counter wraps from 0xFFFF_FFFF to 0.
- R7: Each increment of the seconds counter sets the per-second flag, control bit 6.
- R8: Writing 0 to control bit 6 or bit 4 clears that flag, and writing 1 leaves it unchanged. A flag-setting event in the same cycle as a clearing write wins.
- R9: When control bit 2 (alarm enable) is 1 and the seconds counter equals the alarm register, control bit 4 (alarm flag) is set one clock later. With bit 2 clear, the alarm flag is never set.
- R10: `irq` is high exactly when the per-second flag is set with bit 5 (per-second interrupt enable) set, or when the alarm flag is set with bit 3 (alarm interrupt enable) set.
- R11: Alarm, trim and scratch are plain 32-bit read/write registers. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-clock pulse, once per second |
| busWr | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 6 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
The counter is driven with ticks while counting is disabled and while it is enabled, from the all-ones value, and with a tick that lands in the same cycle as a seconds write. These cases separate a missing enable, a failed wrap and a wrong priority. Writes are tried locked, with a wrong key, while ready is low and after a correct unlock. These cases show whether each gate works on its own and whether the window closes after one write. The flags are cleared with 0 and with 1, and also in a cycle where a new event arrives. The alarm is matched with its enable off and with it on, and with each interrupt enable set alone, which shows that the interrupt follows the right flag.

// File: rtl/rtc_sa_pkg.sv
package rtc_sa_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_SEC  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_ALM  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_TRIM = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_PAD  = 6'h34;
  localparam logic [ADDR_W-1:0] OFS_KEY  = 6'h3C;

  // control word bit positions (software decodes these)
  localparam int B_RUN  = 0;
  localparam int B_AEN  = 2;
  localparam int B_AIE  = 3;
  localparam int B_AFLG = 4;
  localparam int B_SIE  = 5;
  localparam int B_SFLG = 6;
  localparam int B_RDY  = 7;
  localparam int B_UNLK = 31;

  localparam int N_FLG = 2;  // index 0: per-second, index 1: alarm

  typedef struct packed {
    logic ctrlWe;
    logic secWe;
    logic almWe;
    logic trimWe;
    logic padWe;
  } regStrobeT;
endpackage

// File: rtl/rtc_sa_ctrl.sv
module rtc_sa_ctrl
  import rtc_sa_pkg::*;
#(
  parameter int          READY_CYC  = 4,
  parameter logic [15:0] UNLOCK_KEY = 16'hA55A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       keyData,
  output regStrobeT         strobe,
  output logic              writeReady,
  output logic              unlocked
);
  localparam int CW = $clog2(READY_CYC + 1);

  logic [CW-1:0] busyCnt;
  logic          addrMapped;
  logic          keyHit;
  logic          regWr;

  assign writeReady = (busyCnt == '0);

  always_comb begin
    unique case (busAddr)
      OFS_CTRL, OFS_SEC, OFS_ALM, OFS_TRIM, OFS_PAD: addrMapped = 1'b1;
      default: addrMapped = 1'b0;
    endcase
  end

  assign keyHit = busWr && writeReady && (busAddr == OFS_KEY) && (keyData == UNLOCK_KEY);
  assign regWr  = busWr && writeReady && unlocked && addrMapped;

  always_comb begin
    strobe        = '0;
    strobe.ctrlWe = regWr && (busAddr == OFS_CTRL);
    strobe.secWe  = regWr && (busAddr == OFS_SEC);
    strobe.almWe  = regWr && (busAddr == OFS_ALM);
    strobe.trimWe = regWr && (busAddr == OFS_TRIM);
    strobe.padWe  = regWr && (busAddr == OFS_PAD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlocked <= 1'b0;
      busyCnt  <= '0;
    end else begin
      if (regWr)       unlocked <= 1'b0;
      else if (keyHit) unlocked <= 1'b1;

      if (regWr)              busyCnt <= CW'(READY_CYC);
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_sa_dp.sv
module rtc_sa_dp
  import rtc_sa_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  regStrobeT         strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              writeReady,
  input  logic              unlocked,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic [DATA_W-1:0] secCount,
  output logic [DATA_W-1:0] alarmCount,
  output logic              cntEn,
  output logic              almEn,
  output logic              almIe,
  output logic              secIe,
  output logic              secFlag,
  output logic              almFlag
);
  localparam int FLG_POS [N_FLG] = '{B_SFLG, B_AFLG};

  logic [DATA_W-1:0] trimQ;
  logic [DATA_W-1:0] padQ;
  logic              stepNow;
  logic              almHit;
  logic [N_FLG-1:0]  flagQ;
  logic [N_FLG-1:0]  flagSet;
  logic [N_FLG-1:0]  flagIe;
  logic [DATA_W-1:0] ctrlWord;

  assign stepNow = tick && cntEn;
  assign almHit  = almEn && (secCount == alarmCount);
  assign flagSet = {almHit, stepNow};
  assign flagIe  = {almIe, secIe};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secCount   <= '0;
      alarmCount <= '0;
      trimQ      <= '0;
      padQ       <= '0;
      cntEn      <= 1'b0;
      almEn      <= 1'b0;
      almIe      <= 1'b0;
      secIe      <= 1'b0;
    end else begin
      if (strobe.secWe)  secCount <= wdata;
      else if (stepNow)  secCount <= secCount + 1'b1;
      if (strobe.almWe)  alarmCount <= wdata;
      if (strobe.trimWe) trimQ <= wdata;
      if (strobe.padWe)  padQ  <= wdata;
      if (strobe.ctrlWe) begin
        cntEn <= wdata[B_RUN];
        almEn <= wdata[B_AEN];
        almIe <= wdata[B_AIE];
        secIe <= wdata[B_SIE];
      end
    end
  end

  // flags: a written 0 clears, a written 1 keeps, a set event wins
  for (genvar i = 0; i < N_FLG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ[i] <= 1'b0;
      else if (flagSet[i]) flagQ[i] <= 1'b1;
      else if (strobe.ctrlWe && !wdata[FLG_POS[i]]) flagQ[i] <= 1'b0;
    end
  end

  assign secFlag = flagQ[0];
  assign almFlag = flagQ[1];
  assign irq     = |(flagQ & flagIe);

  always_comb begin
    ctrlWord         = '0;
    ctrlWord[B_RUN]  = cntEn;
    ctrlWord[B_AEN]  = almEn;
    ctrlWord[B_AIE]  = almIe;
    ctrlWord[B_AFLG] = almFlag;
    ctrlWord[B_SIE]  = secIe;
    ctrlWord[B_SFLG] = secFlag;
    ctrlWord[B_RDY]  = writeReady;
  end

  always_comb begin
    unique case (rdAddr)
      OFS_CTRL: rdata = ctrlWord;
      OFS_SEC:  rdata = secCount;
      OFS_ALM:  rdata = alarmCount;
      OFS_TRIM: rdata = trimQ;
      OFS_PAD:  rdata = padQ;
      OFS_KEY:  rdata = {unlocked, {(DATA_W-1){1'b0}}};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
  import rtc_sa_pkg::*;
#(
  parameter int          READY_CYC  = 4,
  parameter logic [15:0] UNLOCK_KEY = 16'hA55A
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        busWr,
  input  logic [5:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irq
);
  regStrobeT         strobe;
  logic              writeReady;
  logic              unlocked;
  logic [DATA_W-1:0] secCount;
  logic [DATA_W-1:0] alarmCount;
  logic              cntEn;
  logic              almEn;
  logic              almIe;
  logic              secIe;
  logic              secFlag;
  logic              almFlag;

  rtc_sa_ctrl #(
    .READY_CYC (READY_CYC),
    .UNLOCK_KEY(UNLOCK_KEY)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .keyData   (busWdata[15:0]),
    .strobe    (strobe),
    .writeReady(writeReady),
    .unlocked  (unlocked)
  );

  rtc_sa_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .strobe    (strobe),
    .wdata     (busWdata),
    .rdAddr    (busAddr),
    .writeReady(writeReady),
    .unlocked  (unlocked),
    .rdata     (busRdata),
    .irq       (irq),
    .secCount  (secCount),
    .alarmCount(alarmCount),
    .cntEn     (cntEn),
    .almEn     (almEn),
    .almIe     (almIe),
    .secIe     (secIe),
    .secFlag   (secFlag),
    .almFlag   (almFlag)
  );
endmodule

// File: rtl/rtc_sec_alarm_chk.sv
module rtc_sec_alarm_chk
  import rtc_sa_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        tick,
  input logic        busWr,
  input logic [5:0]  busAddr,
  input logic        irq,
  input logic        writeReady,
  input logic        unlocked,
  input logic [31:0] secCount,
  input logic [31:0] alarmCount,
  input logic        cntEn,
  input logic        almEn,
  input logic        almIe,
  input logic        secIe,
  input logic        almFlag
);
  logic accWr;
  assign accWr = busWr && writeReady && unlocked &&
                 (busAddr == OFS_CTRL || busAddr == OFS_SEC || busAddr == OFS_ALM ||
                  busAddr == OFS_TRIM || busAddr == OFS_PAD);

  // R4
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    accWr |=> !writeReady);

  // R3
  relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    accWr |=> !unlocked);

  // R2
  locked_sec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked && !tick) |=> secCount == $past(secCount));

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cntEn && !(accWr && busAddr == OFS_SEC)) |=> secCount == $past(secCount) + 32'd1);

  // R9
  alarm_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (almEn && secCount == alarmCount) |=> almFlag);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!secIe && !almIe) |-> !irq);
endmodule

bind rtc_sec_alarm rtc_sec_alarm_chk u_chk (.*);

// File: tb/test_rtc_sec_alarm.sv
module test_rtc_sec_alarm;
  localparam int          RDY = 4;
  localparam logic [31:0] KEY = 32'h0000_A55A;
  localparam logic [5:0]  A_CTRL = 6'h00, A_SEC = 6'h04, A_ALM = 6'h08,
                          A_TRIM = 6'h0C, A_PAD = 6'h34, A_KEY = 6'h3C;
  // control bits: 0 run, 2 alarm en, 3 alarm irq en, 4 alarm flag, 5 sec irq en, 6 sec flag
  localparam logic [31:0] KEEPF = 32'h50;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        busWr = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_sec_alarm #(.READY_CYC(RDY), .UNLOCK_KEY(16'hA55A)) i_rtc_sec_alarm (
    .clk(clk), .rstN(rstN), .tick(tick), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic wrRaw(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic waitReady();
    logic [31:0] c;
    for (int i = 0; i < 100; i++) begin
      rd(A_CTRL, c);
      if (c[7]) return;
    end
  endtask

  task automatic writeReg(input logic [5:0] a, input logic [31:0] d);
    waitReady();
    wrRaw(A_KEY, KEY);
    wrRaw(a, d);
  endtask

  task automatic pulseTick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic tReset();
    logic [31:0] d;
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'h80);
    rd(A_SEC, d);  chk("R1 sec", d, 0);
    rd(A_ALM, d);  chk("R1 alarm", d, 0);
    rd(A_PAD, d);  chk("R1 scratch", d, 0);
    rd(A_KEY, d);  chk("R1 unlock", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic tGating();
    logic [31:0] d;
    int cnt;
    wrRaw(A_SEC, 32'h1111);                    // locked
    rd(A_SEC, d); chk("R2 locked write", d, 0);
    wrRaw(A_KEY, 32'h1234);                    // wrong key
    rd(A_KEY, d); chk("R3 wrong key", d, 0);
    wrRaw(A_KEY, KEY);
    rd(A_KEY, d); chk("R3 key opens", d, 32'h8000_0000);
    wrRaw(A_SEC, 32'h2222);
    // now at the first negedge after commit
    cnt = 0; busAddr = A_CTRL; #1;
    while (!busRdata[7] && cnt < 50) begin
      cnt++; @(negedge clk); busAddr = A_CTRL; #1;
    end
    chk("R4 ready low length", cnt, RDY);
    rd(A_SEC, d); chk("R3 write lands", d, 32'h2222);
    rd(A_KEY, d); chk("R3 relocked", d, 0);
    wrRaw(A_SEC, 32'h3333);
    rd(A_SEC, d); chk("R2 second write dropped", d, 32'h2222);
    writeReg(A_PAD, 32'hCAFE_0001);
    wrRaw(A_KEY, KEY);                          // ready low
    rd(A_KEY, d); chk("R4 key while busy", d, 0);
  endtask

  task automatic tCount();
    logic [31:0] d;
    writeReg(A_SEC, 32'd100);
    pulseTick();
    rd(A_SEC, d); chk("R5 no count when off", d, 32'd100);
    writeReg(A_CTRL, KEEPF | 32'h1);
    for (int i = 0; i < 3; i++) pulseTick();
    rd(A_SEC, d); chk("R5 three ticks", d, 32'd103);
    rd(A_CTRL, d); chk("R7 sec flag", d & 32'h40, 32'h40);
    chk("R10 no irq without enable", {31'b0, irq}, 0);
    writeReg(A_SEC, 32'hFFFF_FFFF);
    pulseTick();
    rd(A_SEC, d); chk("R6 wrap", d, 0);
    waitReady();
    wrRaw(A_KEY, KEY);
    @(negedge clk); tick = 1'b1; busWr = 1'b1; busAddr = A_SEC; busWdata = 32'd50;
    @(negedge clk); tick = 1'b0; busWr = 1'b0;
    rd(A_SEC, d); chk("R5 write beats tick", d, 32'd50);
  endtask

  task automatic tFlags();
    logic [31:0] d;
    writeReg(A_CTRL, KEEPF | 32'h21);           // run + sec irq
    rd(A_CTRL, d); chk("R8 write 1 keeps", d & 32'h40, 32'h40);
    chk("R10 sec irq", {31'b0, irq}, 1);
    writeReg(A_CTRL, 32'h21);                   // clear both flags
    rd(A_CTRL, d); chk("R8 write 0 clears", d & 32'h50, 0);
    chk("R10 irq drops", {31'b0, irq}, 0);
    waitReady();
    wrRaw(A_KEY, KEY);
    @(negedge clk); tick = 1'b1; busWr = 1'b1; busAddr = A_CTRL; busWdata = 32'h21;
    @(negedge clk); tick = 1'b0; busWr = 1'b0;
    rd(A_CTRL, d); chk("R8 set wins", d & 32'h40, 32'h40);
  endtask

  task automatic tAlarm();
    logic [31:0] d;
    writeReg(A_CTRL, 32'h0);                    // stop, clear flags
    writeReg(A_SEC, 32'd200);
    writeReg(A_ALM, 32'd200);                   // match, alarm off
    repeat (3) @(negedge clk);
    rd(A_CTRL, d); chk("R9 no flag when disabled", d & 32'h10, 0);
    writeReg(A_ALM, 32'd202);
    rd(A_ALM, d); chk("R11 alarm rw", d, 32'd202);
    writeReg(A_CTRL, KEEPF | 32'h0D);           // run, alarm en, alarm irq
    pulseTick();
    @(negedge clk);
    rd(A_CTRL, d); chk("R9 not yet", d & 32'h10, 0);
    chk("R10 sec flag alone no irq", {31'b0, irq}, 0);
    pulseTick();
    @(negedge clk);
    rd(A_CTRL, d); chk("R9 match sets flag", d & 32'h10, 32'h10);
    chk("R10 alarm irq", {31'b0, irq}, 1);
    pulseTick();                                // move off the match
    writeReg(A_CTRL, 32'h09);                   // alarm en off, clear flags
    rd(A_CTRL, d); chk("R8 alarm flag clears", d & 32'h10, 0);
    chk("R10 irq low", {31'b0, irq}, 0);
  endtask

  task automatic tStore();
    logic [31:0] d;
    writeReg(A_TRIM, 32'h0BAD_F00D);
    rd(A_TRIM, d); chk("R11 trim rw", d, 32'h0BAD_F00D);
    writeReg(A_PAD, 32'h1234_5678);
    rd(A_PAD, d); chk("R11 scratch rw", d, 32'h1234_5678);
    rd(6'h10, d); chk("R11 unmapped", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tGating();
    tCount();
    tFlags();
    tAlarm();
    tStore();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule